// File: doc/BRIEF.md
# Table-Driven Constant Multiplier

This block multiplies an unsigned operand by a constant that is fixed when the design is elaborated. It has no gate-level multiplier and no adder array. The operand is cut into 4-bit slices. Each slice selects an entry from a small table that holds every possible slice value times the constant. The table contents are computed from the constant parameter, and every slice uses an identical table.

The slice results are added together, each one shifted left by four bits times its slice position, to form the full product. A valid flag travels with the data. One optional output register, selected by a parameter, either registers the result or passes it straight through.

Callers set `KVAL` for the constant and drive `operand` together with `in_valid`. They take `product` when `out_valid` is high.

Top module: `const_mult_lut`

## Requirements
- R1: With the output register present (`OUT_REG`=1), the cycle after `in_valid` is high with operand value X, `product` equals X times `KVAL`. This holds for every one of the 256 operand values.
- R2: When `KVAL` is 0, `product` is 0 for every operand value.
- R3: When `KVAL` is 255, the largest operand gives a product of 65025. The 16-bit result never wraps, and `product` never exceeds 255 times `KVAL`.
- R4: With `OUT_REG`=1, `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R5: With `OUT_REG`=0, `product` equals `operand` times `KVAL` in the same cycle, and `out_valid` follows `in_valid` with no delay.
- R6: With `OUT_REG`=1, a clock edge that samples `rst_n` low clears `out_valid` to 0 and `product` to 0, whatever the inputs are.
- R7: With `OUT_REG`=1, a clock edge that samples `in_valid` low leaves `product` unchanged.
- R8: The partial product of the high slice (operand bits 7:4) is weighted by 16. An operand whose low slice is zero, such as 0xF0, gives 16 times its high slice times `KVAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; only used when the output register is present |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `operand` as valid this cycle |
| operand | input | 8 | Unsigned multiplicand |
| out_valid | output | 1 | Marks `product` as valid |
| product | output | 16 | Operand times the constant |

## Verification
The bench sweeps all 256 operands against four instances: constant 0, constant 255, a mixed-bit constant, and a constant with no output register. A wrong table index or a missing zero constant would produce nonzero or scrambled products. A dropped or misplaced shift on the high slice would give wrong results for operands such as 0xF0, while 0x0F would still look correct. An output register that loads while `in_valid` is low would corrupt the held product during idle cycles. A reset that is not honoured would leave a stale product or a stray valid flag.

// File: rtl/cmul_pkg.sv
// Package: shared sizing helpers for the table-driven constant multiplier.
// Assumes the operand width is a whole multiple of the slice width.
package cmul_pkg;

    // Number of slices that cover an operand of width opw.
    function automatic int slice_count(input int opw, input int slice);
        return opw / slice;
    endfunction

    // Width of one partial product: slice bits plus constant bits.
    function automatic int pp_width(input int slice, input int cw);
        return slice + cw;
    endfunction

endpackage

// File: rtl/cmul_slice_rom.sv
// Module: cmul_slice_rom
// Purpose: a 2**SLICE-entry table of idx*KVAL, filled at elaboration time.
// Assumes: KVAL fits in CW bits, so every entry fits in SLICE+CW bits.
module cmul_slice_rom #(
    parameter int SLICE = 4,
    parameter int CW    = 8,
    parameter int KVAL  = 171
) (
    input  logic [SLICE-1:0]    idx,
    output logic [SLICE+CW-1:0] pp
);
    localparam int DEPTH = 2 ** SLICE;
    localparam int PPW   = SLICE + CW;

    logic [PPW-1:0] tbl [DEPTH];

    // Fill each table entry with its index times the constant.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign tbl[e] = PPW'(e * KVAL);
    end

    // Look up the partial product for this slice.
    assign pp = tbl[idx];
endmodule

// File: rtl/cmul_shift_sum.sv
// Module: cmul_shift_sum
// Purpose: weights each slice partial product by 2**(SLICE*position) and adds them.
// Assumes: PW is wide enough to hold the full product, so the sum never wraps.
module cmul_shift_sum #(
    parameter int NSLICE = 2,
    parameter int PPW    = 12,
    parameter int SLICE  = 4,
    parameter int PW     = 16
) (
    input  logic [NSLICE*PPW-1:0] pp_flat,
    output logic [PW-1:0]         sum
);
    // Accumulate the shifted partial products.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NSLICE; i++) begin
            sum = sum + (PW'(pp_flat[i*PPW +: PPW]) << (i * SLICE));
        end
    end
endmodule

// File: rtl/cmul_out_stage.sv
// Module: cmul_out_stage
// Purpose: optional output register for the product and its valid flag.
// Assumes: synchronous active-low reset; the product loads only on valid cycles.
module cmul_out_stage #(
    parameter int PW      = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_valid,
    input  logic [PW-1:0] d_prod,
    output logic          q_valid,
    output logic [PW-1:0] q_prod
);
    if (OUT_REG) begin : g_reg
        // Register the valid flag every cycle and the product on valid only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_prod  <= '0;
            end else begin
                q_valid <= d_valid;
                if (d_valid) q_prod <= d_prod;
            end
        end
    end else begin : g_pass
        // Pass the result straight through with no register.
        assign q_valid = d_valid;
        assign q_prod  = d_prod;
    end
endmodule

// File: rtl/const_mult_lut.sv
// Module: const_mult_lut (top)
// Purpose: multiplies an unsigned operand by the constant KVAL through slice tables.
// Assumes: OPW is a multiple of SLICE and KVAL < 2**CW.
module const_mult_lut #(
    parameter int OPW     = 8,
    parameter int CW      = 8,
    parameter int SLICE   = 4,
    parameter int KVAL    = 171,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OPW-1:0]     operand,
    output logic               out_valid,
    output logic [OPW+CW-1:0]  product
);
    import cmul_pkg::*;

    localparam int NSLICE = slice_count(OPW, SLICE);
    localparam int PPW    = pp_width(SLICE, CW);
    localparam int PW     = OPW + CW;

    logic [NSLICE*PPW-1:0] pp_flat;
    logic [PW-1:0]         raw_prod;

    // One lookup table per operand slice.
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cmul_slice_rom #(.SLICE(SLICE), .CW(CW), .KVAL(KVAL)) u_rom (
            .idx (operand[s*SLICE +: SLICE]),
            .pp  (pp_flat[s*PPW +: PPW])
        );
    end

    cmul_shift_sum #(.NSLICE(NSLICE), .PPW(PPW), .SLICE(SLICE), .PW(PW)) u_sum (
        .pp_flat (pp_flat),
        .sum     (raw_prod)
    );

    cmul_out_stage #(.PW(PW), .OUT_REG(OUT_REG)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_prod  (raw_prod),
        .q_valid (out_valid),
        .q_prod  (product)
    );
endmodule

// File: rtl/cmul_chk.sv
// Module: cmul_chk
// Purpose: assertion checker bound to const_mult_lut; watches its ports only.
// Assumes: the same parameters as the instance it is bound to.
module cmul_chk #(
    parameter int OPW     = 8,
    parameter int CW      = 8,
    parameter int KVAL    = 171,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPW-1:0]    operand,
    input logic              out_valid,
    input logic [OPW+CW-1:0] product
);
    localparam int PW = OPW + CW;
    localparam logic [PW-1:0] MAXP = PW'(2 ** OPW - 1) * PW'(KVAL);

    // Product never exceeds the largest possible result.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product <= MAXP);

    if (OUT_REG) begin : g_reg_chk
        // Valid follows the input one cycle later.
        assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_idle_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // Registered product equals the previous operand times the constant.
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> product == PW'($past(operand)) * PW'(KVAL));
        // Idle cycles hold the product.
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(product));
        // Reset clears the outputs.
        assert_reset_clear_R6: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && product == '0));
    end else begin : g_comb_chk
        // Combinational path follows the inputs in the same cycle.
        assert_comb_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (out_valid && product == PW'(operand) * PW'(KVAL)));
    end
endmodule

bind const_mult_lut cmul_chk #(.OPW(OPW), .CW(CW), .KVAL(KVAL), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/const_mult_lut_tb.sv
module const_mult_lut_tb;
    localparam int K_MAIN = 171;
    localparam int K_ZERO = 0;
    localparam int K_MAX  = 255;
    localparam int K_COMB = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] operand = '0;
    logic v_main, v_zero, v_max, v_comb;
    logic [15:0] p_main, p_zero, p_max, p_comb;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] hold_main, hold_zero, hold_max;

    always #10 clk = ~clk;

    const_mult_lut #(.KVAL(K_MAIN), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(v_main), .product(p_main));
    const_mult_lut #(.KVAL(K_ZERO), .OUT_REG(1'b1)) u_dut_k0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(v_zero), .product(p_zero));
    const_mult_lut #(.KVAL(K_MAX), .OUT_REG(1'b1)) u_dut_kmax (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(v_max), .product(p_max));
    const_mult_lut #(.KVAL(K_COMB), .OUT_REG(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(v_comb), .product(p_comb));

    function automatic logic [15:0] ref_mul(input logic [7:0] x, input int k);
        return 16'(int'(x) * k);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one input at the falling edge, check the comb path, then the registers.
    task automatic apply(input logic [7:0] x, input logic v, input string tag);
        @(negedge clk);
        operand = x;
        in_valid = v;
        #2;
        chk({"R5 comb valid ", tag}, 16'(v_comb), 16'(v));
        if (v) chk({"R5 comb product ", tag}, p_comb, ref_mul(x, K_COMB));
        @(posedge clk);
        #2;
        chk({"R4 valid delay ", tag}, 16'(v_main), 16'(v));
        if (v) begin
            hold_main = ref_mul(x, K_MAIN);
            hold_zero = ref_mul(x, K_ZERO);
            hold_max  = ref_mul(x, K_MAX);
        end
        chk({"R1/R7 main product ", tag}, p_main, hold_main);
        chk({"R2 zero constant ", tag}, p_zero, hold_zero);
        chk({"R3 max constant ", tag}, p_max, hold_max);
    endtask

    task automatic reset_check(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        operand = 8'hFF;
        @(posedge clk);
        #2;
        chk({"R6 reset valid ", tag}, 16'(v_main), 16'd0);
        chk({"R6 reset product ", tag}, p_main, 16'd0);
        chk({"R6 reset product kmax ", tag}, p_max, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        hold_main = '0;
        hold_zero = '0;
        hold_max  = '0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        logic [7:0] r;
        seed = 583;
        void'($urandom(seed));
        hold_main = '0;
        hold_zero = '0;
        hold_max  = '0;
        reset_check("initial");
        // R1 R2 R3: full sweep of operand values.
        for (int i = 0; i < 256; i++) apply(8'(i), 1'b1, "sweep");
        // R8: high-slice weighting and slice corners.
        apply(8'hF0, 1'b1, "R8 hi only");
        chk("R8 hi weight", p_main, 16'(16 * 15 * K_MAIN));
        apply(8'h0F, 1'b1, "R8 lo only");
        apply(8'h10, 1'b1, "R8 bit4");
        chk("R8 bit4 weight", p_main, 16'(16 * K_MAIN));
        apply(8'hFF, 1'b1, "R3 max");
        chk("R3 65025", p_max, 16'd65025);
        // R7: idle cycles hold the last product.
        apply(8'h3C, 1'b0, "R7 idle a");
        apply(8'hC3, 1'b0, "R7 idle b");
        // Random mixed traffic.
        for (int i = 0; i < 400; i++) begin
            r = 8'($urandom());
            apply(r, 1'($urandom() % 2), "random");
        end
        apply(8'h77, 1'b1, "pre reset");
        reset_check("mid run");
        apply(8'h55, 1'b0, "R7 after reset");
        apply(8'hAA, 1'b1, "after reset");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule